// File: doc/BRIEF.md
# General-Purpose I/O Register Bank

This block owns a bank of general-purpose I/O lines and exposes them to software through five word-wide registers on a plain register port: a valid strobe, a write flag, a word address and write data, with read data returned on the clock after the request. Each line has a tri-state pair at the pin side, an output level and an output enable, plus an input level that is brought into the clock domain through a two-stage synchronizer.

Software changes line levels by writing a mask to a write-one-to-set register or to a write-one-to-clear register, so that one line can be changed without a read-modify-write of the others. The data register can also be written to load the whole output latch at once. Line direction is held in one state that has two views. In the output-direction view a 1 means output. In the input-direction view a 1 means input, and that view always reads as the complement of the other. A compile-time switch reverses the numbering, so that line n sits at register bit WIDTH-1-n in every register.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every line is an input (`pin_oe` all zero), the output latch and `pin_out` are all zero, the input-direction register (offset 4) reads all ones, and the output-direction (offset 3) and set (offset 1) registers read zero.
- R2: A write to offset 1 drives high every line whose bit is 1 and leaves the other lines unchanged.
- R3: A write to offset 2 drives low every line whose bit is 1 and leaves the other lines unchanged. A write of zero changes nothing.
- R4: A write to offset 0 loads the whole output latch with the written word.
- R5: A write to offset 3 sets the direction state, with 1 meaning output. `pin_oe` follows it one cycle after the write, and offset 3 reads it back.
- R6: A write to offset 4 sets the same direction state inverted, with 1 meaning input. Offset 4 always reads as the bitwise complement of offset 3.
- R7: A read of offset 0 returns, per line, the output latch for output lines and the synchronized pin input for input lines. A pin change is not seen by a read issued in the same cycle or in the next cycle. It is seen by a read issued two or more cycles after the change.
- R8: A read of offset 1 returns the output latch for all lines, whatever their direction.
- R9: Offset 2 and offsets 5 to 7 read as zero. Read data appears on the clock edge that samples the request, and it holds through idle cycles and writes until the next read.
- R10: With REVERSED=1, line n corresponds to register bit WIDTH-1-n in every register, for writes and for reads.
- R11: `pin_out` always shows the output latch, including for lines that are inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word offset: 0 data, 1 set, 2 clear, 3 output-direction, 4 input-direction |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pin input levels, line order |
| pin_out | output | WIDTH | Pin output levels, line order |
| pin_oe | output | WIDTH | Pin output enables, line order |

## Verification
A corrupted output latch shows on `pin_out` on the clock after the write that caused it, and it shows again on the next read of offset 1. A corrupted direction state shows on `pin_oe` at once, and it shows in the readback of both direction views. A fault in the synchronizer or in the per-line select appears only in data-register reads, so the bench issues reads at exact distances from a pin change to pin down the two-cycle latency. A reversed-numbering fault shows as a mirrored `pin_out` or `pin_oe` on the copy built with REVERSED=1.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  // Word offsets of the register map
  localparam int OFF_DATA = 0;
  localparam int OFF_SET  = 1;
  localparam int OFF_CLR  = 2;
  localparam int OFF_DOUT = 3;
  localparam int OFF_DIN  = 4;
  localparam int REG_COUNT = 5;

  // Minimum offset width able to hold REG_COUNT offsets
  localparam int MIN_ADDR_W = $clog2(REG_COUNT);

  // Reset value of the direction state: all lines inputs
  localparam logic DIR_RESET_BIT = 1'b0;
endpackage

// File: rtl/gpio_bit_order.sv
module gpio_bit_order #(
  parameter int WIDTH    = 32,
  parameter bit REVERSED = 1'b0
) (
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst
);
  generate
    if (REVERSED) begin : g_rev
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dst[i] = src[WIDTH-1-i];
      end
    end else begin : g_fwd
      assign dst = src;
    end
  endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[LAST];
endmodule

// File: rtl/gpio_line_state.sv
module gpio_line_state
  import gpio_regbank_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_word,   // already in line order
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q      // 1 = output
);
  logic [WIDTH-1:0] set_m, clr_m, base, latch_nxt, dir_nxt;
  logic             load_all;

  always_comb begin
    set_m    = '0;
    clr_m    = '0;
    load_all = 1'b0;
    dir_nxt  = dir_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_W'(OFF_DATA): load_all = 1'b1;
        ADDR_W'(OFF_SET):  set_m    = wr_word;
        ADDR_W'(OFF_CLR):  clr_m    = wr_word;
        ADDR_W'(OFF_DOUT): dir_nxt  = wr_word;
        ADDR_W'(OFF_DIN):  dir_nxt  = ~wr_word;
        default: ;
      endcase
    end
    base      = load_all ? wr_word : latch_q;
    // clear is applied last so it dominates a set on the same bit
    latch_nxt = (base | set_m) & ~clr_m;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= {WIDTH{DIR_RESET_BIT}};
    end else begin
      latch_q <= latch_nxt;
      dir_q   <= dir_nxt;
    end
  end
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_regbank_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int ADDR_W   = 3,
  parameter bit REVERSED = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WIDTH-1:0]  level_l,
  input  logic [WIDTH-1:0]  latch_l,
  input  logic [WIDTH-1:0]  dir_l,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] sel_l, sel_b;

  always_comb begin
    case (rd_addr)
      ADDR_W'(OFF_DATA): sel_l = level_l;
      ADDR_W'(OFF_SET):  sel_l = latch_l;
      ADDR_W'(OFF_DOUT): sel_l = dir_l;
      ADDR_W'(OFF_DIN):  sel_l = ~dir_l;
      default:           sel_l = '0;   // clear register and unmapped
    endcase
  end

  gpio_bit_order #(.WIDTH(WIDTH), .REVERSED(REVERSED)) u_rd_order (
    .src (sel_l),
    .dst (sel_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= sel_b;
    end
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int WIDTH       = 32,   // 8, 16, 32 or 64
  parameter bit REVERSED    = 1'b0,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  localparam int USED_ADDR_W = (ADDR_W < MIN_ADDR_W) ? MIN_ADDR_W : ADDR_W;

  logic             wr_en, rd_en;
  logic [WIDTH-1:0] wword_l, pin_sync, latch_l, dir_l, level_l;

  assign wr_en = bus_valid &  bus_write;
  assign rd_en = bus_valid & ~bus_write;

  gpio_bit_order #(.WIDTH(WIDTH), .REVERSED(REVERSED)) u_wr_order (
    .src (bus_wdata),
    .dst (wword_l)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_line_state #(.WIDTH(WIDTH), .ADDR_W(USED_ADDR_W)) u_state (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (USED_ADDR_W'(bus_addr)),
    .wr_word (wword_l),
    .latch_q (latch_l),
    .dir_q   (dir_l)
  );

  // per-line level: own drive for outputs, sampled pin for inputs
  assign level_l = (dir_l & latch_l) | (~dir_l & pin_sync);

  gpio_readback #(.WIDTH(WIDTH), .ADDR_W(USED_ADDR_W), .REVERSED(REVERSED)) u_rb (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (USED_ADDR_W'(bus_addr)),
    .level_l (level_l),
    .latch_l (latch_l),
    .dir_l   (dir_l),
    .rdata   (bus_rdata)
  );

  assign pin_out = latch_l;
  assign pin_oe  = dir_l;
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int WIDTH    = 32,
  parameter bit REVERSED = 1'b0,
  parameter int ADDR_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe
);
  function automatic logic [WIDTH-1:0] to_lines(input logic [WIDTH-1:0] w);
    logic [WIDTH-1:0] o;
    for (int i = 0; i < WIDTH; i++) o[i] = REVERSED ? w[WIDTH-1-i] : w[i];
    return o;
  endfunction

  logic wr_set, wr_clr, wr_dout, wr_din, rd_req, rd_dead;
  logic [WIDTH-1:0] wl;

  assign wl      = to_lines(bus_wdata);
  assign wr_set  = bus_valid && bus_write && (bus_addr == ADDR_W'(1));
  assign wr_clr  = bus_valid && bus_write && (bus_addr == ADDR_W'(2));
  assign wr_dout = bus_valid && bus_write && (bus_addr == ADDR_W'(3));
  assign wr_din  = bus_valid && bus_write && (bus_addr == ADDR_W'(4));
  assign rd_req  = bus_valid && !bus_write;
  assign rd_dead = rd_req && ((bus_addr == ADDR_W'(2)) || (bus_addr > ADDR_W'(4)));

  p_reset_clean_r1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0) && (pin_out == '0));

  p_set_mask_r2: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((pin_out & $past(wl)) == $past(wl)) &&
               ((pin_out & ~$past(wl)) == ($past(pin_out) & ~$past(wl))));

  p_clr_mask_r3: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((pin_out & $past(wl)) == '0) &&
               ((pin_out & ~$past(wl)) == ($past(pin_out) & ~$past(wl))));

  p_dout_load_r5: assert property (@(posedge clk) disable iff (rst)
    wr_dout |=> (pin_oe == $past(wl)));

  p_din_invert_r6: assert property (@(posedge clk) disable iff (rst)
    wr_din |=> (pin_oe == ~$past(wl)));

  p_dir_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_dout || wr_din) |=> $stable(pin_oe));

  p_dead_read_r9: assert property (@(posedge clk) disable iff (rst)
    rd_dead |=> (bus_rdata == '0));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(bus_rdata));
endmodule

bind gpio_regbank gpio_regbank_chk #(
  .WIDTH(WIDTH), .REVERSED(REVERSED), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_regbank_tb.sv
`timescale 1ns/1ps
module gpio_regbank_tb;
  localparam int W  = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr  = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  pin_in    = '0;
  logic [W-1:0]  bus_rdata, pin_out, pin_oe;
  logic [W-1:0]  rev_rdata, rev_pin_out, rev_pin_oe;

  always #2 clk = ~clk;   // 250 MHz

  gpio_regbank #(.WIDTH(W), .REVERSED(1'b0), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  gpio_regbank #(.WIDTH(W), .REVERSED(1'b1), .ADDR_W(AW)) u_rev (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rev_rdata),
    .pin_in(pin_in), .pin_out(rev_pin_out), .pin_oe(rev_pin_oe));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct { logic [W-1:0] exp; string tag; } item_t;
  item_t sb_q[$];

  // bench model, line order equals bit order for u_dut
  logic [W-1:0] m_latch = '0;
  logic [W-1:0] m_dir   = '0;

  function automatic logic [W-1:0] mirror(input logic [W-1:0] v);
    logic [W-1:0] o;
    for (int i = 0; i < W; i++) o[i] = v[W-1-i];
    return o;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [W-1:0] data);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    case (addr)
      0: m_latch = data;
      1: m_latch = m_latch | data;
      2: m_latch = m_latch & ~data;
      3: m_dir   = data;
      4: m_dir   = ~data;
      default: ;
    endcase
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input int addr, input logic [W-1:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(addr);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // monitor: compare read data against the queue
  logic rd_pend = 1'b0;
  always @(posedge clk) rd_pend <= bus_valid & ~bus_write & ~rst;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    rd(4, 16'hFFFF, "R1 input-direction");
    rd(3, 16'h0000, "R1 output-direction");
    rd(1, 16'h0000, "R1 set readback");

    // dead offsets
    rd(2, 16'h0000, "R9 clear reads zero");
    rd(5, 16'h0000, "R9 offset5");
    rd(7, 16'h0000, "R9 offset7");

    // set
    wr(1, 16'h00F0);
    chk("R2 set first", pin_out, m_latch);
    wr(1, 16'h0101);
    chk("R2 set keeps others", pin_out, 16'h01F1);
    rd(1, 16'h01F1, "R8 latch readback");

    // clear
    wr(2, 16'h0031);
    chk("R3 clear", pin_out, 16'h01C0);
    wr(2, 16'h0000);
    chk("R3 zero clear", pin_out, 16'h01C0);

    // data write loads latch
    wr(0, 16'hA5C3);
    chk("R4 data load", pin_out, 16'hA5C3);

    // output direction
    wr(3, 16'hFF00);
    chk("R5 pin_oe", pin_oe, 16'hFF00);
    rd(3, 16'hFF00, "R5 readback");
    rd(4, 16'h00FF, "R6 complement view");

    // pin synchronizer latency
    pin_in = 16'h1234;
    rd(0, 16'hA500, "R7 same cycle old");
    rd(0, 16'hA500, "R7 next cycle old");
    rd(0, 16'hA534, "R7 two cycles new");

    // input direction write
    wr(4, 16'h0F0F);
    chk("R6 pin_oe", pin_oe, 16'hF0F0);
    rd(3, 16'hF0F0, "R6 dout view");
    rd(4, 16'h0F0F, "R6 din view");
    rd(0, 16'hA2C4, "R7 mixed directions");
    chk("R10 reversed data read", rev_rdata,
        (m_dir & m_latch) | (~m_dir & mirror(pin_in)));
    rd(1, 16'hA5C3, "R8 latch with inputs");
    chk("R10 reversed latch read", rev_rdata, 16'hA5C3);
    chk("R11 pin_out on inputs", pin_out, 16'hA5C3);

    // read data holds
    repeat (3) @(negedge clk);
    chk("R9 hold idle", bus_rdata, 16'hA5C3);
    wr(1, 16'hFFFF);
    chk("R9 hold over write", bus_rdata, 16'hA5C3);

    // reversed numbering at the pins
    wr(2, 16'hFFFF);
    wr(1, 16'h0001);
    chk("R2 single line", pin_out, 16'h0001);
    chk("R10 reversed pin_out", rev_pin_out, mirror(m_latch));
    chk("R10 reversed pin_oe", rev_pin_oe, mirror(m_dir));

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9 missing read data actual=%0d expected=0 pending", sb_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule